// File: doc/BRIEF.md
# Multichannel DMA Context-Switch Engine

This block moves byte elements from one memory address to another for several independent channels. All channels share one data mover. A channel becomes pending when its hardware request line pulses, or when another channel that chains to it finishes. Pending channels take turns in round-robin order. Each turn moves at most four elements and then gives the mover up.

Every channel has two register sets. The primary set is written by software and holds the start addresses, the element and frame counts, and the mode bits. The working set holds the channel's saved live context: the next source address, the next destination address and the remaining counts. The working set is written only when the channel's turn ends. A read in the middle of a turn therefore returns the snapshot from the last switch and not the live position.

Software programs the primary words, sets the enable bit and then raises requests. It can poll the working words to follow progress, with the granularity of one turn.

Top module: `dma_ctx_engine`

## Requirements
- R1: After reset there is no memory access, every register word reads zero and every channel is disabled. A request on a disabled channel starts no transfer.
- R2: Register address layout. The top address bit (bit 6 at the defaults) selects the working set (1) or the primary set (0). Bits [5:4] select the channel, so the channel stride is 0x10. Bits [3:2] select the word:
  - word 0 is the source address;
  - word 1 is the destination address;
  - word 2 holds the counts, elements in bits [7:0] and frames in bits [23:16];
  - word 3 is the control word in the primary set and the valid flag (bit 0) in the working set.
  Control bits: 0 enable, 1 auto-reinit, 2 one-frame-per-request, 3 source increment, 4 destination increment, [15:8] chain target. Primary words read back as written.
- R3: A write to any primary word of a channel clears that channel's working valid flag. A turn starts from the primary context when the working set is invalid, and from the working set otherwise.
- R4: Each element takes one read cycle. The data returned by the read is written in the next cycle. Read and write never happen in the same cycle. An address advances by 1 per element when its increment bit is set and stays fixed otherwise.
- R5: Turns go round-robin, starting the search at the channel after the one served last. A turn moves at most 4 elements and ends early at a frame boundary.
- R6: A channel's working set changes only in the cycle after one of its turns ends. Reads at any other time return the last saved snapshot.
- R7: At the end of a turn the channel saves its next source address, next destination address, elements left in the current frame and frames left, and marks the working set valid. For a 16-element frame the saved element count is 12 after the first turn. The next turn continues from that point.
- R8: In one-frame-per-request mode a request moves one frame and then clears the pending bit. Otherwise a request moves elements × frames before the pending bit clears.
- R9: When a channel finishes its block, a chain target K other than 0 makes channel K−1 pending, provided that channel is enabled. A chain target of 0 triggers nothing.
- R10: At block completion the working valid flag is cleared. With auto-reinit set, the enable bit stays set and the next request restarts from the primary context. Otherwise the enable bit clears and later requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NCH | Hardware request, one per channel |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | $clog2(NCH)+5 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |

## Verification
The checker watches every cycle for four things:
- read and write never overlap, and every write follows a read (R4);
- no turn writes more than four elements (R5);
- a working word on the read port changes only after a turn ends or after a register write (R6);
- a chain trigger hits at most one channel, and only at a switch-out (R9).

Only the bench scenarios can show the saved counts at each switch, the interleaved order of two channels, frame-by-frame pacing, and the fact that a chained channel starts only after its predecessor's last element. They also show the effect of auto-reinit against self-disable on later requests.

// File: rtl/dma_ctx_pkg.sv
package dma_ctx_pkg;
   localparam int REG_W = 32;
   // register word select, address bits [3:2]
   localparam int WD_SRC = 0;
   localparam int WD_DST = 1;
   localparam int WD_CNT = 2;
   localparam int WD_CTL = 3;
   // primary control word bits
   localparam int CTL_EN        = 0;
   localparam int CTL_AUTO      = 1;
   localparam int CTL_FRAME     = 2;
   localparam int CTL_INCS      = 3;
   localparam int CTL_INCD      = 4;
   localparam int CTL_CHAIN_LSB = 8;
   localparam int CTL_CHAIN_W   = 8;
   // count word: frames start here, elements start at bit 0
   localparam int CNT_FRM_LSB   = 16;

   typedef enum logic [2:0] {
      MV_IDLE, MV_LOAD, MV_READ, MV_WRITE, MV_SAVE
   } mv_state_e;
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
   parameter int NCH = 4,
   parameter int IW  = 2
) (
   input  logic [NCH-1:0] ready,
   input  logic [IW-1:0]  last,
   output logic           any,
   output logic [IW-1:0]  pick
);
   generate
      if ((NCH & (NCH - 1)) == 0) begin : g_pow2
         // index wraps by truncation
         always_comb begin
            any  = 1'b0;
            pick = last;
            for (int k = 1; k <= NCH; k++) begin
               if (!any && ready[IW'(last + IW'(k))]) begin
                  any  = 1'b1;
                  pick = IW'(last + IW'(k));
               end
            end
         end
      end else begin : g_mod
         always_comb begin
            any  = 1'b0;
            pick = last;
            for (int k = 1; k <= NCH; k++) begin
               if (!any && ready[(int'(last) + k) % NCH]) begin
                  any  = 1'b1;
                  pick = IW'((int'(last) + k) % NCH);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dma_pkt_bank.sv
module dma_pkt_bank import dma_ctx_pkg::*; #(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int ECW = 8,
   parameter int FCW = 8,
   parameter int IW  = 2,
   parameter int RAW = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [RAW-1:0]   cfg_addr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic [NCH-1:0]   req_i,
   input  logic [NCH-1:0]   chain_set,
   input  logic             save_stb,
   input  logic             sv_pend_clr,
   input  logic             sv_en_clr,
   input  logic             sv_valid,
   input  logic [AW-1:0]    sv_src,
   input  logic [AW-1:0]    sv_dst,
   input  logic [ECW-1:0]   sv_elems,
   input  logic [FCW-1:0]   sv_frames,
   input  logic [IW-1:0]    view_ch,
   output logic [AW-1:0]    p_src,
   output logic [AW-1:0]    p_dst,
   output logic [ECW-1:0]   p_elems,
   output logic [FCW-1:0]   p_frames,
   output logic [15:0]      p_ctl,
   output logic [AW-1:0]    w_src,
   output logic [AW-1:0]    w_dst,
   output logic [ECW-1:0]   w_elems,
   output logic [FCW-1:0]   w_frames,
   output logic             w_valid,
   output logic [NCH-1:0]   ready
);
   logic [AW-1:0]  ps_q [NCH];
   logic [AW-1:0]  pd_q [NCH];
   logic [ECW-1:0] pe_q [NCH];
   logic [FCW-1:0] pf_q [NCH];
   logic [15:0]    pc_q [NCH];
   logic [AW-1:0]  ws_q [NCH];
   logic [AW-1:0]  wd_q [NCH];
   logic [ECW-1:0] wel_q [NCH];
   logic [FCW-1:0] wf_q [NCH];
   logic [NCH-1:0] wv_q, pend_q;

   logic [IW-1:0] a_ch;
   logic [1:0]    a_wd;
   logic          a_work;
   logic          unused_bits;

   assign a_ch        = cfg_addr[RAW-2:4];
   assign a_wd        = cfg_addr[3:2];
   assign a_work      = cfg_addr[RAW-1];
   assign unused_bits = ^{cfg_wdata, cfg_addr[1:0]};

   function automatic logic [REG_W-1:0] pack_cnt(input logic [ECW-1:0] e,
                                                 input logic [FCW-1:0] f);
      pack_cnt = '0;
      pack_cnt[ECW-1:0] = e;
      pack_cnt[CNT_FRM_LSB +: FCW] = f;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            ps_q[i] <= '0; pd_q[i] <= '0; pe_q[i] <= '0; pf_q[i] <= '0;
            pc_q[i] <= '0; ws_q[i] <= '0; wd_q[i] <= '0; wel_q[i] <= '0;
            wf_q[i] <= '0;
         end
         wv_q   <= '0;
         pend_q <= '0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (cfg_we && !a_work && a_ch == IW'(i)) begin
               case (a_wd)
                  2'(WD_SRC): ps_q[i] <= cfg_wdata[AW-1:0];
                  2'(WD_DST): pd_q[i] <= cfg_wdata[AW-1:0];
                  2'(WD_CNT): begin
                     pe_q[i] <= cfg_wdata[ECW-1:0];
                     pf_q[i] <= cfg_wdata[CNT_FRM_LSB +: FCW];
                  end
                  default:    pc_q[i] <= cfg_wdata[15:0];
               endcase
               wv_q[i] <= 1'b0;
            end
            if (save_stb && view_ch == IW'(i)) begin
               ws_q[i]  <= sv_src;
               wd_q[i]  <= sv_dst;
               wel_q[i] <= sv_elems;
               wf_q[i]  <= sv_frames;
               wv_q[i]  <= sv_valid;
               if (sv_en_clr) pc_q[i][CTL_EN] <= 1'b0;
            end
            pend_q[i] <= (pend_q[i] & ~(save_stb && view_ch == IW'(i) && sv_pend_clr))
                       | ((req_i[i] | chain_set[i]) & pc_q[i][CTL_EN]);
         end
      end
   end

   always_comb begin
      for (int i = 0; i < NCH; i++) ready[i] = pend_q[i] & pc_q[i][CTL_EN];
   end

   assign p_src    = ps_q[view_ch];
   assign p_dst    = pd_q[view_ch];
   assign p_elems  = pe_q[view_ch];
   assign p_frames = pf_q[view_ch];
   assign p_ctl    = pc_q[view_ch];
   assign w_src    = ws_q[view_ch];
   assign w_dst    = wd_q[view_ch];
   assign w_elems  = wel_q[view_ch];
   assign w_frames = wf_q[view_ch];
   assign w_valid  = wv_q[view_ch];

   always_comb begin
      cfg_rdata = '0;
      if (a_work) begin
         case (a_wd)
            2'(WD_SRC): cfg_rdata[AW-1:0] = ws_q[a_ch];
            2'(WD_DST): cfg_rdata[AW-1:0] = wd_q[a_ch];
            2'(WD_CNT): cfg_rdata = pack_cnt(wel_q[a_ch], wf_q[a_ch]);
            default:    cfg_rdata[0] = wv_q[a_ch];
         endcase
      end else begin
         case (a_wd)
            2'(WD_SRC): cfg_rdata[AW-1:0] = ps_q[a_ch];
            2'(WD_DST): cfg_rdata[AW-1:0] = pd_q[a_ch];
            2'(WD_CNT): cfg_rdata = pack_cnt(pe_q[a_ch], pf_q[a_ch]);
            default:    cfg_rdata[15:0] = pc_q[a_ch];
         endcase
      end
   end
endmodule

// File: rtl/dma_mover.sv
module dma_mover import dma_ctx_pkg::*; #(
   parameter int NCH   = 4,
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int ECW   = 8,
   parameter int FCW   = 8,
   parameter int IW    = 2,
   parameter int BURST = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           arb_any,
   input  logic [IW-1:0]  arb_pick,
   input  logic [AW-1:0]  p_src,
   input  logic [AW-1:0]  p_dst,
   input  logic [ECW-1:0] p_elems,
   input  logic [FCW-1:0] p_frames,
   input  logic [15:0]    p_ctl,
   input  logic [AW-1:0]  w_src,
   input  logic [AW-1:0]  w_dst,
   input  logic [ECW-1:0] w_elems,
   input  logic [FCW-1:0] w_frames,
   input  logic           w_valid,
   input  logic [DW-1:0]  mem_rd_data,
   output logic [IW-1:0]  cur_ch,
   output logic           mem_rd_en,
   output logic [AW-1:0]  mem_rd_addr,
   output logic           mem_wr_en,
   output logic [AW-1:0]  mem_wr_addr,
   output logic [DW-1:0]  mem_wr_data,
   output logic           save_stb,
   output logic           sv_pend_clr,
   output logic           sv_en_clr,
   output logic           sv_valid,
   output logic [AW-1:0]  sv_src,
   output logic [AW-1:0]  sv_dst,
   output logic [ECW-1:0] sv_elems,
   output logic [FCW-1:0] sv_frames,
   output logic [NCH-1:0] chain_set
);
   localparam int BW = $clog2(BURST + 1);

   mv_state_e      st_q;
   logic [AW-1:0]  src_q, dst_q;
   logic [ECW-1:0] elems_q;
   logic [FCW-1:0] frames_q;
   logic [BW-1:0]  burst_q;
   logic           frame_end_q, block_end_q;
   logic [CTL_CHAIN_W-1:0] chain_k;
   logic           unused_ctl;

   assign chain_k    = p_ctl[CTL_CHAIN_LSB +: CTL_CHAIN_W];
   assign unused_ctl = ^p_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= MV_IDLE;
         cur_ch      <= IW'(NCH - 1);
         src_q       <= '0;
         dst_q       <= '0;
         elems_q     <= '0;
         frames_q    <= '0;
         burst_q     <= '0;
         frame_end_q <= 1'b0;
         block_end_q <= 1'b0;
      end else begin
         case (st_q)
            MV_IDLE: if (arb_any) begin
               cur_ch <= arb_pick;
               st_q   <= MV_LOAD;
            end
            MV_LOAD: begin
               src_q       <= w_valid ? w_src    : p_src;
               dst_q       <= w_valid ? w_dst    : p_dst;
               elems_q     <= w_valid ? w_elems  : p_elems;
               frames_q    <= w_valid ? w_frames : p_frames;
               burst_q     <= '0;
               frame_end_q <= 1'b0;
               block_end_q <= 1'b0;
               st_q        <= MV_READ;
            end
            MV_READ: st_q <= MV_WRITE;
            MV_WRITE: begin
               src_q   <= src_q + AW'(p_ctl[CTL_INCS]);
               dst_q   <= dst_q + AW'(p_ctl[CTL_INCD]);
               burst_q <= burst_q + 1'b1;
               if (elems_q == ECW'(1)) begin
                  frame_end_q <= 1'b1;
                  if (frames_q == FCW'(1)) begin
                     block_end_q <= 1'b1;
                     elems_q     <= '0;
                     frames_q    <= '0;
                  end else begin
                     elems_q  <= p_elems;
                     frames_q <= frames_q - 1'b1;
                  end
                  st_q <= MV_SAVE;
               end else begin
                  elems_q <= elems_q - 1'b1;
                  st_q    <= (burst_q == BW'(BURST - 1)) ? MV_SAVE : MV_READ;
               end
            end
            default: st_q <= MV_IDLE;
         endcase
      end
   end

   assign mem_rd_en   = (st_q == MV_READ);
   assign mem_rd_addr = src_q;
   assign mem_wr_en   = (st_q == MV_WRITE);
   assign mem_wr_addr = dst_q;
   assign mem_wr_data = mem_rd_data;

   assign save_stb    = (st_q == MV_SAVE);
   assign sv_src      = src_q;
   assign sv_dst      = dst_q;
   assign sv_elems    = elems_q;
   assign sv_frames   = frames_q;
   assign sv_valid    = !block_end_q;
   assign sv_pend_clr = block_end_q | (frame_end_q & p_ctl[CTL_FRAME]);
   assign sv_en_clr   = block_end_q & !p_ctl[CTL_AUTO];

   always_comb begin
      for (int i = 0; i < NCH; i++)
         chain_set[i] = save_stb && block_end_q && (chain_k == CTL_CHAIN_W'(i + 1));
   end
endmodule

// File: rtl/dma_ctx_engine.sv
module dma_ctx_engine import dma_ctx_pkg::*; #(
   parameter int NCH   = 4,
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int ECW   = 8,
   parameter int FCW   = 8,
   parameter int BURST = 4,
   localparam int IW   = $clog2(NCH),
   localparam int RAW  = IW + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   req_i,
   input  logic             cfg_we,
   input  logic [RAW-1:0]   cfg_addr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic             mem_rd_en,
   output logic [AW-1:0]    mem_rd_addr,
   input  logic [DW-1:0]    mem_rd_data,
   output logic             mem_wr_en,
   output logic [AW-1:0]    mem_wr_addr,
   output logic [DW-1:0]    mem_wr_data
);
   generate
      if (NCH < 2 || NCH > 255) begin : g_bad_nch
         $error("NCH must lie in 2..255");
      end
      if (AW < 1 || AW > REG_W) begin : g_bad_aw
         $error("AW must lie in 1..32");
      end
      if (ECW < 1 || ECW > CNT_FRM_LSB || FCW < 1 || FCW > REG_W - CNT_FRM_LSB) begin : g_bad_cnt
         $error("count widths must fit their register fields");
      end
      if (BURST < 1) begin : g_bad_burst
         $error("BURST must be at least 1");
      end
   endgenerate

   logic           arb_any;
   logic [IW-1:0]  arb_pick, cur_ch;
   logic [NCH-1:0] ready, chain_set;
   logic           save_stb, sv_pend_clr, sv_en_clr, sv_valid, w_valid;
   logic [AW-1:0]  sv_src, sv_dst, p_src, p_dst, w_src, w_dst;
   logic [ECW-1:0] sv_elems, p_elems, w_elems;
   logic [FCW-1:0] sv_frames, p_frames, w_frames;
   logic [15:0]    p_ctl;

   dma_rr_arb #(.NCH(NCH), .IW(IW)) u_arb (
      .ready(ready), .last(cur_ch), .any(arb_any), .pick(arb_pick)
   );

   dma_pkt_bank #(.NCH(NCH), .AW(AW), .ECW(ECW), .FCW(FCW), .IW(IW), .RAW(RAW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .req_i(req_i), .chain_set(chain_set),
      .save_stb(save_stb), .sv_pend_clr(sv_pend_clr), .sv_en_clr(sv_en_clr),
      .sv_valid(sv_valid), .sv_src(sv_src), .sv_dst(sv_dst),
      .sv_elems(sv_elems), .sv_frames(sv_frames), .view_ch(cur_ch),
      .p_src(p_src), .p_dst(p_dst), .p_elems(p_elems), .p_frames(p_frames), .p_ctl(p_ctl),
      .w_src(w_src), .w_dst(w_dst), .w_elems(w_elems), .w_frames(w_frames),
      .w_valid(w_valid), .ready(ready)
   );

   dma_mover #(.NCH(NCH), .AW(AW), .DW(DW), .ECW(ECW), .FCW(FCW), .IW(IW), .BURST(BURST)) u_mover (
      .clk(clk), .rst_n(rst_n), .arb_any(arb_any), .arb_pick(arb_pick),
      .p_src(p_src), .p_dst(p_dst), .p_elems(p_elems), .p_frames(p_frames), .p_ctl(p_ctl),
      .w_src(w_src), .w_dst(w_dst), .w_elems(w_elems), .w_frames(w_frames), .w_valid(w_valid),
      .mem_rd_data(mem_rd_data), .cur_ch(cur_ch),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .save_stb(save_stb), .sv_pend_clr(sv_pend_clr), .sv_en_clr(sv_en_clr),
      .sv_valid(sv_valid), .sv_src(sv_src), .sv_dst(sv_dst),
      .sv_elems(sv_elems), .sv_frames(sv_frames), .chain_set(chain_set)
   );
endmodule

// File: rtl/dma_ctx_engine_chk.sv
module dma_ctx_engine_chk #(
   parameter int NCH   = 4,
   parameter int BURST = 4,
   localparam int RAW  = $clog2(NCH) + 5,
   localparam int CW   = $clog2(BURST + 1) + 1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cfg_we,
   input logic [RAW-1:0] cfg_addr,
   input logic [31:0]    cfg_rdata,
   input logic           mem_rd_en,
   input logic           mem_wr_en,
   input logic           save_stb,
   input logic [NCH-1:0] chain_set
);
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         run_q <= '0;
      else if (save_stb)  run_q <= '0;
      else if (mem_wr_en) run_q <= run_q + 1'b1;
   end

   AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en)); // R4
   AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> $past(mem_rd_en)); // R4
   AST_TURN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (run_q < CW'(BURST))); // R5
   AST_SNAPSHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_addr[RAW-1] && $stable(cfg_addr) && !$past(save_stb) && !$past(cfg_we))
      |-> $stable(cfg_rdata)); // R6
   AST_CHAIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chain_set)); // R9
   AST_CHAIN_AT_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (chain_set != '0) |-> save_stb); // R9
endmodule

bind dma_ctx_engine dma_ctx_engine_chk #(.NCH(NCH), .BURST(BURST)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
   .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .save_stb(save_stb), .chain_set(chain_set)
);

// File: tb/dma_ctx_engine_tb.sv
module dma_ctx_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 4;
   localparam int RAW   = 7;
   localparam int WBASE = 64;
   localparam int C_EN = 1, C_AUTO = 2, C_FRM = 4, C_INCS = 8, C_INCD = 16;

   logic        clk, rst_n, cfg_we;
   logic [3:0]  req_i;
   logic [RAW-1:0] cfg_addr;
   logic [31:0] cfg_wdata, cfg_rdata;
   logic        mem_rd_en, mem_wr_en;
   logic [15:0] mem_rd_addr, mem_wr_addr;
   logic [7:0]  mem_rd_data, mem_wr_data;
   logic [7:0]  mem [0:4095];

   typedef struct packed { logic [15:0] addr; logic [7:0] data; } exp_t;
   exp_t sb[$];
   int n_chk = 0, n_bad = 0, wr_seen = 0;

   dma_ctx_engine u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];
      if (mem_wr_en) mem[mem_wr_addr[11:0]] <= mem_wr_data;
   end

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 7 + 3);
   endfunction

   task automatic check_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pop the scoreboard on every write
   always @(negedge clk) begin : mon
      exp_t e;
      if (rst_n && mem_wr_en) begin
         wr_seen++;
         if (sb.size() == 0) check_eq("R4", "unexpected write addr", 32'(mem_wr_addr), 32'hFFFF_FFFF);
         else begin
            e = sb.pop_front();
            check_eq("R4", "write addr", 32'(mem_wr_addr), 32'(e.addr));
            check_eq("R4", "write data", 32'(mem_wr_data), 32'(e.data));
         end
      end
   end

   task automatic push_run(input int src, input int dst, input int first, input int len, input bit incs);
      for (int i = first; i < first + len; i++)
         sb.push_back('{addr: 16'(dst + i), data: pat(incs ? src + i : src)});
   endtask

   task automatic cfg_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = RAW'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = RAW'(a);
      #1 d = cfg_rdata;
   endtask

   task automatic prog(input int ch, input int src, input int dst, input int el, input int fr, input int ctl);
      cfg_wr(ch * 16 + 0, 32'(src));
      cfg_wr(ch * 16 + 4, 32'(dst));
      cfg_wr(ch * 16 + 8, 32'((fr << 16) | el));
      cfg_wr(ch * 16 + 12, 32'(ctl));
   endtask

   task automatic pulse(input logic [3:0] v);
      @(negedge clk); req_i = v;
      @(negedge clk); req_i = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] d;
      bit mem_ok;
      for (int i = 0; i < 4096; i++) mem[i] = pat(i);
      rst_n = 1'b0; cfg_we = 1'b0; req_i = '0; cfg_addr = '0; cfg_wdata = '0;
      idle(5);
      rst_n = 1'b1;

      // R1 reset state and disabled channel
      check_eq("R1", "rd_en", 32'(mem_rd_en), 0);
      check_eq("R1", "wr_en", 32'(mem_wr_en), 0);
      cfg_rd(WBASE + 8, d);  check_eq("R1", "working count ch0", d, 0);
      cfg_rd(WBASE + 12, d); check_eq("R1", "working valid ch0", d, 0);
      cfg_rd(2 * 16 + 12, d); check_eq("R1", "primary control ch2", d, 0);
      pulse(4'b0100); idle(10);
      check_eq("R1", "writes after disabled request", wr_seen, 0);

      // scenario 1: two 16-element channels interleaved
      prog(0, 'h100, 'h400, 16, 1, C_EN | C_INCS | C_INCD);
      prog(1, 'h200, 'h500, 16, 1, C_EN | C_AUTO | C_INCS | C_INCD);
      cfg_rd(16 + 8, d);  check_eq("R2", "primary count ch1", d, 32'h0001_0010);
      cfg_rd(16 + 0, d);  check_eq("R2", "primary source ch1", d, 32'h200);
      cfg_rd(WBASE + 16 + 12, d); check_eq("R3", "valid after primary write", d, 0);
      for (int b = 0; b < 4; b++) begin
         push_run('h100, 'h400, 4 * b, 4, 1'b1);
         push_run('h200, 'h500, 4 * b, 4, 1'b1);
      end
      pulse(4'b0011);
      wait (wr_seen >= 2);
      cfg_rd(WBASE + 8, d); check_eq("R6", "ch0 count mid first turn", d, 0);
      wait (wr_seen >= 5);
      cfg_rd(WBASE + 8, d);  check_eq("R7", "ch0 count after first turn", d, 32'h0001_000C);
      cfg_rd(WBASE + 0, d);  check_eq("R7", "ch0 saved source", d, 32'h104);
      cfg_rd(WBASE + 4, d);  check_eq("R7", "ch0 saved destination", d, 32'h404);
      cfg_rd(WBASE + 12, d); check_eq("R7", "ch0 working valid", d, 1);
      wait (wr_seen >= 9);
      cfg_rd(WBASE + 16 + 8, d); check_eq("R5", "ch1 yielded after four", d, 32'h0001_000C);
      wait (wr_seen >= 10);
      cfg_rd(WBASE + 8, d); check_eq("R6", "ch0 snapshot while live", d, 32'h0001_000C);
      wait (wr_seen >= 13);
      cfg_rd(WBASE + 8, d); check_eq("R7", "ch0 count after second turn", d, 32'h0001_0008);
      wait (wr_seen >= 32);
      idle(12);
      check_eq("R5", "scoreboard drained", sb.size(), 0);
      check_eq("R9", "no chain with target 0", wr_seen, 32);
      mem_ok = 1'b1;
      for (int i = 0; i < 16; i++) if (mem[16'h400 + i] !== mem[16'h100 + i]) mem_ok = 1'b0;
      check_eq("R4", "destination equals source", 32'(mem_ok), 1);
      cfg_rd(12, d);         check_eq("R10", "ch0 disabled at end", d, 32'h18);
      cfg_rd(16 + 12, d);    check_eq("R10", "ch1 stays enabled", d, 32'h1B);
      cfg_rd(WBASE + 16 + 12, d); check_eq("R10", "ch1 working invalid", d, 0);

      // auto-reinit restart of ch1; ch0 request ignored
      push_run('h200, 'h500, 0, 16, 1'b1);
      pulse(4'b0011);
      wait (wr_seen >= 48);
      idle(12);
      check_eq("R10", "ch1 restart and ch0 ignored", wr_seen, 48);
      check_eq("R3", "restart from primary drained", sb.size(), 0);

      // scenario 2: frame-paced ch2 chaining to ch3 (fixed source)
      prog(2, 'h120, 'h600, 3, 2, C_EN | C_FRM | C_INCS | C_INCD | (4 << 8));
      prog(3, 'h230, 'h700, 5, 1, C_EN | C_INCD);
      push_run('h120, 'h600, 0, 3, 1'b1);
      pulse(4'b0100);
      wait (wr_seen >= 51);
      idle(12);
      check_eq("R8", "one frame per request", wr_seen, 51);
      cfg_rd(WBASE + 32 + 8, d); check_eq("R8", "ch2 saved after frame", d, 32'h0001_0003);
      push_run('h120, 'h600, 3, 3, 1'b1);
      push_run('h230, 'h700, 0, 5, 1'b0);
      pulse(4'b0100);
      wait (wr_seen >= 59);
      idle(12);
      check_eq("R9", "chained channel ran after predecessor", wr_seen, 59);
      check_eq("R9", "chain scoreboard drained", sb.size(), 0);
      cfg_rd(32 + 12, d); check_eq("R10", "ch2 disabled after block", d, 32'h41C);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule